// File: doc/BRIEF.md
# Pointer-exchange memory execution slice

This block executes one instruction per clock cycle, applied directly as a 32-bit word. It holds a 32 x 32-bit register file with two write ports, a word-indexed data memory, a sign extender, the address adders and a program counter. Besides ordinary add-immediate, load-word and store-word, it runs a custom exchange instruction. In a single cycle the exchange stores the value of rt at the address held in rs. It loads the word at address rs + rt into rt, and moves the pointer in rs by a signed immediate.

A two-state controller sequences the block. After reset it sits in `ST_CLEAR` and sweeps the data memory to zero, one word per cycle, with `ready_o` low. When the sweep counter reaches the last word, the transition `CLEAR_DONE` moves it to `ST_RUN`. It stays there until the next reset. Instructions are taken only in `ST_RUN` while `instr_vld_i` is high. The two writeback ports are brought out so that a caller can see each retired result.

Top module: `pxch_exec`

## Requirements
- R1: After reset, `ready_o` is low while all data-memory words are cleared. It then rises and stays high. Registers and memory read as zero before any write.
- R2: The PC starts at 0 and grows by 4 in each cycle where `ready_o` and `instr_vld_i` are both high. Otherwise it holds.
- R3: Exchange uses opcode 6'h3F, rs in bits 25:21, rt in bits 20:16 and imm in bits 15:0. It writes the old value of rt to the memory word at the old value of rs.
- R4: Exchange writes the word at address (old rs + old rt) into rt. The memory is read before it is written, so equal load and store addresses return the earlier contents.
- R5: Exchange writes old rs + sign-extended imm into rs. Both register writes land at the same clock edge.
- R6: When exchange names the same register as rs and rt, the pointer value is the one kept and the load writeback is suppressed (`wrl_en_o` low).
- R7: Writes to register 0 are dropped, with the matching enable output low, and register 0 reads as zero.
- R8: If any memory address used by a lw, sw or exchange has bits 1:0 non-zero, `err_o` is high in that cycle. That instruction then writes no register and no memory, and the PC still advances.
- R9: Add-immediate (6'h08: rt = rs + sext(imm)), load-word (6'h23: rt = mem[rs + sext(imm)]) and store-word (6'h2B: mem[rs + sext(imm)] = rt) keep their usual behaviour.
- R10: Any other opcode writes nothing and raises no error.
- R11: Memory words are selected by address bits 9:2. Higher address bits are ignored, so address 0x508 names the same word as 0x108.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction word |
| instr_vld_i | input | 1 | Instruction present this cycle |
| ready_o | output | 1 | High once the memory sweep is finished |
| pc_o | output | 32 | Program counter |
| err_o | output | 1 | Misaligned address on the current instruction |
| wrp_en_o | output | 1 | Pointer/ALU write port commits at the next edge |
| wrp_idx_o | output | 5 | Pointer/ALU write register index |
| wrp_data_o | output | 32 | Pointer/ALU write data |
| wrl_en_o | output | 1 | Load write port commits at the next edge |
| wrl_idx_o | output | 5 | Load write register index |
| wrl_data_o | output | 32 | Load write data |

## Verification
The functions that collide are the memory read and the memory write of one exchange, and the two register writebacks of one exchange. To make the addresses collide, the bench gives rt the value 0 while rs points at a known word. The load must return the old word, and a later load must return the new one. To make the writebacks collide, the bench names the same register as rs and rt. The write is judged by `wrl_en_o` staying low and by an add-immediate read-back that shows the pointer value.

// File: rtl/pxch_pkg.sv
package pxch_pkg;
    localparam int XLEN = 32;
    localparam int RIDX = 5;

    localparam logic [5:0] OPC_ADDI = 6'h08;
    localparam logic [5:0] OPC_LW   = 6'h23;
    localparam logic [5:0] OPC_SW   = 6'h2B;
    localparam logic [5:0] OPC_XCH  = 6'h3F;

    typedef enum logic [2:0] {
        K_NONE,
        K_ADDI,
        K_LW,
        K_SW,
        K_XCH
    } kind_e;

    typedef enum logic {
        ST_CLEAR,
        ST_RUN
    } st_e;

    typedef struct packed {
        kind_e             kind;
        logic [RIDX-1:0]   rs;
        logic [RIDX-1:0]   rt;
        logic [XLEN-1:0]   imm;
    } dec_t;
endpackage

// File: rtl/pxch_decode.sv
module pxch_decode
    import pxch_pkg::*;
(
    input  logic [31:0] instr_i,
    output dec_t        dec_o
);
    always_comb begin
        dec_o.rs  = instr_i[25:21];
        dec_o.rt  = instr_i[20:16];
        dec_o.imm = {{(XLEN-16){instr_i[15]}}, instr_i[15:0]};
        unique case (instr_i[31:26])
            OPC_ADDI: dec_o.kind = K_ADDI;
            OPC_LW:   dec_o.kind = K_LW;
            OPC_SW:   dec_o.kind = K_SW;
            OPC_XCH:  dec_o.kind = K_XCH;
            default:  dec_o.kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/pxch_regfile.sv
module pxch_regfile #(
    parameter int NREG = 32,
    parameter int XLEN = 32,
    localparam int RIDX = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RIDX-1:0] ra_idx,
    output logic [XLEN-1:0] ra_data,
    input  logic [RIDX-1:0] rb_idx,
    output logic [XLEN-1:0] rb_data,
    input  logic            p_we,
    input  logic [RIDX-1:0] p_idx,
    input  logic [XLEN-1:0] p_data,
    input  logic            l_we,
    input  logic [RIDX-1:0] l_idx,
    input  logic [XLEN-1:0] l_data
);
    logic [XLEN-1:0] regs [NREG];

    assign ra_data = (ra_idx == '0) ? '0 : regs[ra_idx];
    assign rb_data = (rb_idx == '0) ? '0 : regs[rb_idx];

    // pointer port is tested first: it wins on a shared index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else begin
            for (int i = 1; i < NREG; i++) begin
                if (p_we && p_idx == RIDX'(i))      regs[i] <= p_data;
                else if (l_we && l_idx == RIDX'(i)) regs[i] <= l_data;
            end
        end
    end

    a_r6_pointer_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (p_we && l_we && p_idx == l_idx && p_idx != '0)
        |=> regs[$past(p_idx)] == $past(p_data));

    a_r7_zero_kept: assert property (@(posedge clk) disable iff (!rst_n)
        regs[0] == '0);
endmodule

// File: rtl/pxch_dmem.sv
module pxch_dmem #(
    parameter int WORDS = 256,
    parameter int XLEN  = 32,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   rd_idx,
    output logic [XLEN-1:0] rd_data,
    input  logic            we,
    input  logic [AW-1:0]   wr_idx,
    input  logic [XLEN-1:0] wr_data
);
    logic [XLEN-1:0] mem [WORDS];

    // combinational read sees the contents from before this edge
    assign rd_data = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (we) mem[wr_idx] <= wr_data;
    end

    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/pxch_exec.sv
module pxch_exec
    import pxch_pkg::*;
#(
    parameter int          MEM_WORDS = 256,
    parameter logic [31:0] RESET_PC  = 32'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] instr_i,
    input  logic        instr_vld_i,
    output logic        ready_o,
    output logic [31:0] pc_o,
    output logic        err_o,
    output logic        wrp_en_o,
    output logic [4:0]  wrp_idx_o,
    output logic [31:0] wrp_data_o,
    output logic        wrl_en_o,
    output logic [4:0]  wrl_idx_o,
    output logic [31:0] wrl_data_o
);
    localparam int AW = $clog2(MEM_WORDS);

    st_e             st_q;
    logic [AW-1:0]   clr_q;
    logic [31:0]     pc_q;
    dec_t            dec;
    logic [XLEN-1:0] rs_val, rt_val, ld_addr, st_addr, ld_word;
    logic            go, uses_ld, uses_st, misal, ok, clearing;
    logic            p_we, l_we, m_we;
    logic [AW-1:0]   m_widx;
    logic [XLEN-1:0] m_wdata;

    pxch_decode u_dec (.instr_i(instr_i), .dec_o(dec));

    pxch_regfile #(.NREG(32), .XLEN(XLEN)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .ra_idx(dec.rs), .ra_data(rs_val),
        .rb_idx(dec.rt), .rb_data(rt_val),
        .p_we(p_we), .p_idx(wrp_idx_o), .p_data(wrp_data_o),
        .l_we(l_we), .l_idx(wrl_idx_o), .l_data(ld_word)
    );

    pxch_dmem #(.WORDS(MEM_WORDS), .XLEN(XLEN)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(ld_addr[AW+1:2]), .rd_data(ld_word),
        .we(m_we), .wr_idx(m_widx), .wr_data(m_wdata)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_CLEAR;
            clr_q <= '0;
        end else begin
            unique case (st_q)
                ST_CLEAR: begin
                    clr_q <= clr_q + 1'b1;
                    if (clr_q == AW'(MEM_WORDS - 1)) st_q <= ST_RUN;
                end
                ST_RUN: st_q <= ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  pc_q <= RESET_PC;
        else if (go) pc_q <= pc_q + 32'd4;
    end

    // outputs and datapath control
    always_comb begin
        clearing = 1'b0;
        ready_o  = 1'b0;
        unique case (st_q)
            ST_CLEAR: clearing = 1'b1;
            ST_RUN:   ready_o  = 1'b1;
        endcase
        go      = ready_o && instr_vld_i;
        uses_ld = (dec.kind == K_LW) || (dec.kind == K_XCH);
        uses_st = (dec.kind == K_SW) || (dec.kind == K_XCH);
        ld_addr = (dec.kind == K_XCH) ? rs_val + rt_val : rs_val + dec.imm;
        st_addr = (dec.kind == K_XCH) ? rs_val : rs_val + dec.imm;
        misal   = (uses_ld && ld_addr[1:0] != 2'b00) ||
                  (uses_st && st_addr[1:0] != 2'b00);
        err_o   = go && misal;
        ok      = go && !misal;

        wrp_idx_o  = (dec.kind == K_XCH) ? dec.rs : dec.rt;
        wrp_data_o = rs_val + dec.imm;
        p_we       = ok && ((dec.kind == K_XCH) || (dec.kind == K_ADDI))
                     && wrp_idx_o != '0;
        wrp_en_o   = p_we;

        wrl_idx_o  = dec.rt;
        wrl_data_o = ld_word;
        l_we       = ok && uses_ld && dec.rt != '0;
        wrl_en_o   = l_we && !(p_we && wrp_idx_o == dec.rt);

        m_we    = clearing || (ok && uses_st);
        m_widx  = clearing ? clr_q : st_addr[AW+1:2];
        m_wdata = clearing ? '0 : rt_val;
    end

    assign pc_o = pc_q;

    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && instr_vld_i) |=> pc_o == $past(pc_o) + 32'd4);

    a_r2_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready_o && instr_vld_i) |=> $stable(pc_o));

    a_r8_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !wrp_en_o && !wrl_en_o && !u_mem.we);

    a_r1_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> ready_o);
endmodule

// File: tb/pxch_exec_tb.sv
`timescale 1ns/1ps
module pxch_exec_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic        vld = 1'b0;
    logic        ready, err, pe, le;
    logic [31:0] pc, pd, ld;
    logic [4:0]  pi, li;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    logic [31:0] exp_pc = 32'h0;
    logic        c_err, c_pe, c_le;
    logic [4:0]  c_pi, c_li;
    logic [31:0] c_pd, c_ld;

    always #2.5 clk = ~clk;

    pxch_exec dut_i (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .instr_vld_i(vld),
        .ready_o(ready), .pc_o(pc), .err_o(err),
        .wrp_en_o(pe), .wrp_idx_o(pi), .wrp_data_o(pd),
        .wrl_en_o(le), .wrl_idx_o(li), .wrl_data_o(ld)
    );

    function automatic logic [31:0] enc(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // apply one word, capture pre-edge outputs, check the PC step (R2)
    task automatic issue(input logic [31:0] w);
        @(negedge clk);
        instr = w; vld = 1'b1;
        #1;
        c_err = err; c_pe = pe; c_pi = pi; c_pd = pd;
        c_le = le; c_li = li; c_ld = ld;
        @(posedge clk);
        #1;
        vld = 1'b0;
        exp_pc = exp_pc + 32'd4;
        chk("R2 pc step", pc, exp_pc);
    endtask

    task automatic read_reg(input logic [4:0] r, output logic [31:0] v);
        issue(enc(6'h08, r, 5'd31, 16'h0));
        v = c_pd;
    endtask

    task automatic read_mem(input logic [15:0] a, output logic [31:0] v);
        issue(enc(6'h23, 5'd0, 5'd30, a));
        v = c_ld;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        #1;
        chk("R1 ready low in reset", {31'b0, ready}, 32'h0);
        chk("R2 pc reset value", pc, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        instr = enc(6'h08, 5'd0, 5'd14, 16'h0055); vld = 1'b1;
        repeat (10) @(negedge clk);
        chk("R1 ready low during sweep", {31'b0, ready}, 32'h0);
        while (!ready) @(negedge clk);
        vld = 1'b0;
        chk("R2 pc held during sweep", pc, 32'h0);
        read_mem(16'h03FC, v); chk("R1 memory cleared", v, 32'h0);
        read_reg(5'd14, v);    chk("R1 register zero, no write in sweep", v, 32'h0);
    endtask

    task automatic t_legacy();
        issue(enc(6'h08, 5'd0, 5'd1, 16'h0100));
        chk("R9 addi en", {31'b0, c_pe}, 32'h1);
        chk("R9 addi idx", {27'b0, c_pi}, 32'h1);
        chk("R9 addi data", c_pd, 32'h100);
        issue(enc(6'h08, 5'd0, 5'd2, 16'h0008));
        issue(enc(6'h08, 5'd0, 5'd5, 16'h1234));
        issue(enc(6'h2B, 5'd1, 5'd5, 16'h0008));
        issue(enc(6'h08, 5'd0, 5'd6, 16'h0077));
        issue(enc(6'h2B, 5'd1, 5'd6, 16'h0004));
        issue(enc(6'h23, 5'd1, 5'd7, 16'h0008));
        chk("R9 lw en", {31'b0, c_le}, 32'h1);
        chk("R9 lw idx", {27'b0, c_li}, 32'd7);
        chk("R9 lw data after sw", c_ld, 32'h1234);
    endtask

    task automatic t_xch_basic();
        logic [31:0] v;
        issue(enc(6'h3F, 5'd1, 5'd2, 16'h0004));
        chk("R5 pointer idx", {27'b0, c_pi}, 32'd1);
        chk("R5 pointer data", c_pd, 32'h104);
        chk("R4 load en", {31'b0, c_le}, 32'h1);
        chk("R4 load data", c_ld, 32'h1234);
        chk("R8 no err aligned", {31'b0, c_err}, 32'h0);
        read_mem(16'h0100, v); chk("R3 stored old rt", v, 32'h8);
        read_reg(5'd1, v);     chk("R5 rs updated", v, 32'h104);
        read_reg(5'd2, v);     chk("R4 rt loaded", v, 32'h1234);
    endtask

    task automatic t_same_addr();
        logic [31:0] v;
        issue(enc(6'h08, 5'd0, 5'd8, 16'h0000));
        issue(enc(6'h3F, 5'd1, 5'd8, 16'h0000));
        chk("R4 read before write", c_ld, 32'h77);
        read_reg(5'd8, v);     chk("R4 rt got old word", v, 32'h77);
        read_mem(16'h0104, v); chk("R3 new word stored", v, 32'h0);
    endtask

    task automatic t_alias();
        logic [31:0] v;
        issue(enc(6'h08, 5'd0, 5'd9, 16'h0080));
        issue(enc(6'h3F, 5'd9, 5'd9, 16'hFFFC));
        chk("R6 load port suppressed", {31'b0, c_le}, 32'h0);
        chk("R5 negative imm", c_pd, 32'h7C);
        read_reg(5'd9, v);     chk("R6 pointer kept", v, 32'h7C);
        read_mem(16'h0080, v); chk("R3 alias store", v, 32'h80);
    endtask

    task automatic t_misalign();
        logic [31:0] v;
        issue(enc(6'h08, 5'd0, 5'd10, 16'h0102));
        issue(enc(6'h3F, 5'd10, 5'd2, 16'h0004));
        chk("R8 err xch", {31'b0, c_err}, 32'h1);
        chk("R8 no writes xch", {30'b0, c_pe, c_le}, 32'h0);
        read_reg(5'd10, v);    chk("R8 rs unchanged", v, 32'h102);
        read_reg(5'd2, v);     chk("R8 rt unchanged", v, 32'h1234);
        read_mem(16'h0100, v); chk("R8 memory unchanged", v, 32'h8);
        issue(enc(6'h23, 5'd1, 5'd11, 16'h0001));
        chk("R8 err lw", {31'b0, c_err}, 32'h1);
        read_reg(5'd11, v);    chk("R8 lw target unchanged", v, 32'h0);
    endtask

    task automatic t_zero_unknown();
        logic [31:0] v;
        issue(enc(6'h08, 5'd0, 5'd0, 16'h0005));
        chk("R7 r0 write dropped", {31'b0, c_pe}, 32'h0);
        read_reg(5'd0, v);  chk("R7 r0 reads zero", v, 32'h0);
        issue(enc(6'h3E, 5'd1, 5'd12, 16'h0004));
        chk("R10 unknown silent", {29'b0, c_pe, c_le, c_err}, 32'h0);
        read_reg(5'd12, v); chk("R10 target unchanged", v, 32'h0);
    endtask

    task automatic t_wrap_hold();
        issue(enc(6'h08, 5'd0, 5'd12, 16'h0500));
        issue(enc(6'h23, 5'd12, 5'd13, 16'h0008));
        chk("R11 upper bits ignored", c_ld, 32'h1234);
        repeat (3) @(negedge clk);
        chk("R2 pc holds idle", pc, exp_pc);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_legacy();
        t_xch_basic();
        t_same_addr();
        t_alias();
        t_misalign();
        t_zero_unknown();
        t_wrap_hold();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule